// File: doc/BRIEF.md
# Paged NIC Register File

This block is the byte-wide host-facing register file of an Ethernet controller. A host reaches it through a small port window: a port offset, separate read and write strobes, and an access-size qualifier. Apart from the command register, which answers at offset 0 whatever the page, the register space is split into banks. Bits [7:6] of the command register select the bank.

The block holds the configuration that the remote-DMA engine and the receive engine use: the receive ring bounds, the ring pointers, the remote address and length, the station address and the group-address filter mask. It also holds the interrupt status and mask. A status bit can be set by a pulse from a neighbouring engine, or by a side effect of a command write. The host clears a status bit by writing a one to it.

A command write can cause three side effects. It can leave the reset state. It can flag a remote transfer of zero length as already complete. It can launch a transmission. A launch is a one-cycle request that carries the transmit start page and the 16-bit byte count.

Top module: `nic_reg_bank`

## Requirements
- R1: After reset, the command register reads 0x22 and the interrupt status reads 0x80 (bit 7, the reset flag). The interrupt mask and the transmit status are 0x00, all 64 bits of the group mask output are ones, and `irq` and `txReq` are low.
- R2: Only `portAddr[4:0]` is decoded, so any address whose low five bits match an offset reaches that register.
- R3: Offset 0 is the command register on every page.
  - Any other offset is decoded on the page in command bits [7:6].
  - Page 0, writes: 1 ring first page, 2 ring last page, 3 read pointer, 4 transmit page, 5/6 transmit length low/high, 7 interrupt status, 8/9 remote address low/high, 0xA/0xB remote length low/high, 0xC receive mode, 0xD transmit mode, 0xE bus config, 0xF interrupt mask.
  - Page 0, reads: 1/2 local address low/high, 3 read pointer, 4 transmit status, 7 interrupt status.
  - Page 1, reads and writes: 1..6 station address bytes 0..5, 7 write page, 8..0xF group mask bytes 0..7.
  - Page 2, writes: 1/2 local address low/high, 3 next remote page, 5 next local page, 6/7 address counter high/low.
  - Page 2, reads: the same four registers, plus 1 ring first, 2 ring last, 4 transmit page, 0xC receive mode, 0xD transmit mode, 0xE bus config, 0xF interrupt mask.
  - Page 3 holds nothing.
- R4: A write of V to the interrupt status clears each bit i in 0..6 where V[i] is 1. Status bit 7 is never changed by this write.
- R5: `irq` is a register. It equals the OR of (status AND mask AND 0x7F) from the previous cycle, so status bit 7 never raises it.
- R6: A command write with bit 0 (stop) clear clears status bit 7. A command write with bit 0 set leaves status bit 7 unchanged. Nothing other than reset sets status bit 7.
- R7: A command write with stop clear that requests a remote read (bit 3) or a remote write (bit 4) while the remote length is 0 sets status bit 6. With a nonzero remote length, bit 6 is not set.
- R8: A command write with stop clear and bit 2 (transmit) set does four things:
  - it raises `txReq` for exactly one cycle, starting on the edge that takes the write, with `txPage` and `txCount` equal to the transmit page and length;
  - it sets the transmit status to 0x01;
  - it sets status bit 1;
  - it stores the command with bit 2 cleared.
  A transmit write with stop set issues no request.
- R9: Every 16-bit register is written as two byte halves. Writing one half leaves the other half unchanged.
- R10: Reads of unimplemented offsets return 0x00. An access with `accSize` other than 0 (byte) writes nothing, causes no side effect and reads 0x00.
- R11: Each bit of `statusSet` is ORed into status bits 6..0 on the next edge. If the host clears the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portAddr | input | ADDR_W | Host port address; only bits [4:0] are decoded |
| accSize | input | 2 | Access size: 0 byte, 1 half word, 2 word |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational on the read strobe |
| statusSet | input | 7 | Status-set pulses from the neighbouring engines |
| irq | output | 1 | Registered interrupt request |
| cmdOut | output | 8 | Current command register |
| ringFirst | output | 8 | Receive ring first page |
| ringLast | output | 8 | Receive ring last page |
| readPtr | output | 8 | Receive ring read pointer |
| writePg | output | 8 | Receive ring write page |
| rxMode | output | 8 | Receive mode |
| txMode | output | 8 | Transmit mode |
| busCfg | output | 8 | Bus configuration |
| dmaAddr | output | 16 | Remote start address |
| dmaLen | output | 16 | Remote byte count |
| stationAddr | output | 48 | Station address; byte 0 in bits [7:0] |
| groupMask | output | 64 | Group filter mask; byte 0 in bits [7:0] |
| txReq | output | 1 | One-cycle transmit request |
| txPage | output | 8 | Transmit start page |
| txCount | output | 16 | Transmit byte count |

## Verification
The hardest case to reach from the ports is a status-set pulse and a host clear of the same bit landing in the same cycle. The bench drives `statusSet` and a write to status offset 7 in the same cycle, then reads the status back.

Status bit 7 together with an all-ones mask is also hard to reach, because almost any command write clears that bit. The bench reaches it by writing the mask right after a reset while page 0 is still selected, and issuing no command write before it checks `irq`.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;
  localparam int BYTE_W        = 8;
  localparam int WORD_W        = 16;
  localparam int OFS_W         = 5;
  localparam int STAT_SET_W    = 7;
  localparam int STATION_BYTES = 6;
  localparam int GROUP_BYTES   = 8;
  localparam int IDX_W         = 3;

  localparam int CMD_STOP_BIT = 0;
  localparam int CMD_TX_BIT   = 2;
  localparam int CMD_DRD_BIT  = 3;
  localparam int CMD_DWR_BIT  = 4;

  localparam int ST_TX_DONE  = 1;
  localparam int ST_DMA_DONE = 6;
  localparam int ST_RESET    = 7;

  localparam logic [BYTE_W-1:0] CMD_RST     = 8'h22;
  localparam logic [BYTE_W-1:0] STAT_RST    = 8'h80;
  localparam logic [BYTE_W-1:0] TX_STAT_OK  = 8'h01;
  localparam logic [BYTE_W-1:0] IRQ_FIELD   = 8'h7F;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_CMD, SEL_RING_FIRST, SEL_RING_LAST, SEL_READ_PTR,
    SEL_TX_PAGE, SEL_TX_LEN_LO, SEL_TX_LEN_HI, SEL_INT_STAT,
    SEL_DMA_ADDR_LO, SEL_DMA_ADDR_HI, SEL_DMA_LEN_LO, SEL_DMA_LEN_HI,
    SEL_RX_MODE, SEL_TX_MODE, SEL_BUS_CFG, SEL_INT_MASK,
    SEL_STATION, SEL_WRITE_PG, SEL_GROUP,
    SEL_LOCAL_LO, SEL_LOCAL_HI, SEL_NEXT_REM, SEL_NEXT_LOC,
    SEL_CNT_LO, SEL_CNT_HI, SEL_TX_STAT
  } regSel_e;

  typedef struct packed {
    logic              wrStb;
    regSel_e           wrSel;
    logic [IDX_W-1:0]  wrIdx;
    logic              rdStb;
    regSel_e           rdSel;
    logic [IDX_W-1:0]  rdIdx;
    logic              clrResetBit;
    logic              setDmaDone;
    logic              txFire;
    logic [BYTE_W-1:0] data;
  } ctrlStb_t;
endpackage

// File: rtl/nic_reg_ctrl.sv
module nic_reg_ctrl
  import nic_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] portAddr,
  input  logic [1:0]        accSize,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] cmdReg,
  input  logic              dmaLenZero,
  output ctrlStb_t          stb
);
  logic [OFS_W-1:0] ofs;
  logic [1:0]       page;
  logic             byteAcc;
  logic             cmdWr;
  logic             running;
  regSel_e          wrSel;
  regSel_e          rdSel;
  logic [IDX_W-1:0] stationIdx;
  logic [IDX_W-1:0] groupIdx;

  assign ofs        = portAddr[OFS_W-1:0];
  assign page       = cmdReg[7:6];
  assign byteAcc    = (accSize == 2'd0);
  assign stationIdx = IDX_W'(ofs - 5'd1);
  assign groupIdx   = IDX_W'(ofs - 5'd8);

  // write-side decode
  always_comb begin
    wrSel = SEL_NONE;
    if (ofs == 5'd0) begin
      wrSel = SEL_CMD;
    end else begin
      unique case (page)
        2'd0: begin
          case (ofs)
            5'h01: wrSel = SEL_RING_FIRST;
            5'h02: wrSel = SEL_RING_LAST;
            5'h03: wrSel = SEL_READ_PTR;
            5'h04: wrSel = SEL_TX_PAGE;
            5'h05: wrSel = SEL_TX_LEN_LO;
            5'h06: wrSel = SEL_TX_LEN_HI;
            5'h07: wrSel = SEL_INT_STAT;
            5'h08: wrSel = SEL_DMA_ADDR_LO;
            5'h09: wrSel = SEL_DMA_ADDR_HI;
            5'h0A: wrSel = SEL_DMA_LEN_LO;
            5'h0B: wrSel = SEL_DMA_LEN_HI;
            5'h0C: wrSel = SEL_RX_MODE;
            5'h0D: wrSel = SEL_TX_MODE;
            5'h0E: wrSel = SEL_BUS_CFG;
            5'h0F: wrSel = SEL_INT_MASK;
            default: wrSel = SEL_NONE;
          endcase
        end
        2'd1: begin
          if (ofs >= 5'h01 && ofs <= 5'h06)      wrSel = SEL_STATION;
          else if (ofs == 5'h07)                 wrSel = SEL_WRITE_PG;
          else if (ofs >= 5'h08 && ofs <= 5'h0F) wrSel = SEL_GROUP;
        end
        2'd2: begin
          case (ofs)
            5'h01: wrSel = SEL_LOCAL_LO;
            5'h02: wrSel = SEL_LOCAL_HI;
            5'h03: wrSel = SEL_NEXT_REM;
            5'h05: wrSel = SEL_NEXT_LOC;
            5'h06: wrSel = SEL_CNT_HI;
            5'h07: wrSel = SEL_CNT_LO;
            default: wrSel = SEL_NONE;
          endcase
        end
        default: wrSel = SEL_NONE;
      endcase
    end
  end

  // read-side decode
  always_comb begin
    rdSel = SEL_NONE;
    if (ofs == 5'd0) begin
      rdSel = SEL_CMD;
    end else begin
      unique case (page)
        2'd0: begin
          case (ofs)
            5'h01: rdSel = SEL_LOCAL_LO;
            5'h02: rdSel = SEL_LOCAL_HI;
            5'h03: rdSel = SEL_READ_PTR;
            5'h04: rdSel = SEL_TX_STAT;
            5'h07: rdSel = SEL_INT_STAT;
            default: rdSel = SEL_NONE;
          endcase
        end
        2'd1: begin
          if (ofs >= 5'h01 && ofs <= 5'h06)      rdSel = SEL_STATION;
          else if (ofs == 5'h07)                 rdSel = SEL_WRITE_PG;
          else if (ofs >= 5'h08 && ofs <= 5'h0F) rdSel = SEL_GROUP;
        end
        2'd2: begin
          case (ofs)
            5'h01: rdSel = SEL_RING_FIRST;
            5'h02: rdSel = SEL_RING_LAST;
            5'h03: rdSel = SEL_NEXT_REM;
            5'h04: rdSel = SEL_TX_PAGE;
            5'h05: rdSel = SEL_NEXT_LOC;
            5'h06: rdSel = SEL_CNT_HI;
            5'h07: rdSel = SEL_CNT_LO;
            5'h0C: rdSel = SEL_RX_MODE;
            5'h0D: rdSel = SEL_TX_MODE;
            5'h0E: rdSel = SEL_BUS_CFG;
            5'h0F: rdSel = SEL_INT_MASK;
            default: rdSel = SEL_NONE;
          endcase
        end
        default: rdSel = SEL_NONE;
      endcase
    end
  end

  assign cmdWr   = wrEn && byteAcc && (wrSel == SEL_CMD);
  assign running = !wrData[CMD_STOP_BIT];

  always_comb begin
    stb.wrStb       = wrEn && byteAcc;
    stb.wrSel       = wrSel;
    stb.wrIdx       = (wrSel == SEL_GROUP) ? groupIdx : stationIdx;
    stb.rdStb       = rdEn && byteAcc;
    stb.rdSel       = rdSel;
    stb.rdIdx       = (rdSel == SEL_GROUP) ? groupIdx : stationIdx;
    stb.clrResetBit = cmdWr && running;
    stb.setDmaDone  = cmdWr && running && dmaLenZero &&
                      (wrData[CMD_DRD_BIT] || wrData[CMD_DWR_BIT]);
    stb.txFire      = cmdWr && running && wrData[CMD_TX_BIT];
    stb.data        = wrData;
  end
endmodule

// File: rtl/nic_reg_dp.sv
module nic_reg_dp
  import nic_reg_pkg::*;
#(
  parameter logic [STATION_BYTES*BYTE_W-1:0] STATION_RST = '0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStb_t                        stb,
  input  logic [STAT_SET_W-1:0]           statusSet,
  output logic [BYTE_W-1:0]               rdData,
  output logic                            irq,
  output logic [BYTE_W-1:0]               cmdReg,
  output logic                            dmaLenZero,
  output logic [BYTE_W-1:0]               intStat,
  output logic [BYTE_W-1:0]               intMask,
  output logic [BYTE_W-1:0]               ringFirst,
  output logic [BYTE_W-1:0]               ringLast,
  output logic [BYTE_W-1:0]               readPtr,
  output logic [BYTE_W-1:0]               writePg,
  output logic [BYTE_W-1:0]               rxMode,
  output logic [BYTE_W-1:0]               txMode,
  output logic [BYTE_W-1:0]               busCfg,
  output logic [WORD_W-1:0]               dmaAddr,
  output logic [WORD_W-1:0]               dmaLen,
  output logic [STATION_BYTES*BYTE_W-1:0] stationAddr,
  output logic [GROUP_BYTES*BYTE_W-1:0]   groupMask,
  output logic                            txReq,
  output logic [BYTE_W-1:0]               txPage,
  output logic [WORD_W-1:0]               txCount
);
  localparam int IDX_SLOTS = 1 << IDX_W;

  logic [BYTE_W-1:0] txStat;
  logic [WORD_W-1:0] localAddr;
  logic [WORD_W-1:0] addrCnt;
  logic [BYTE_W-1:0] nextRem;
  logic [BYTE_W-1:0] nextLoc;
  logic [BYTE_W-1:0] stationRd [IDX_SLOTS];
  logic [BYTE_W-1:0] groupRd   [IDX_SLOTS];
  logic [BYTE_W-1:0] statClr;
  logic [BYTE_W-1:0] statSet;
  logic              wrHit;

  function automatic logic hit(input ctrlStb_t s, input regSel_e sel);
    return s.wrStb && (s.wrSel == sel);
  endfunction

  assign dmaLenZero = (dmaLen == '0);
  assign wrHit      = hit(stb, SEL_INT_STAT);

  // status clear and set vectors; a set overrides a clear of the same bit
  always_comb begin
    statClr = wrHit ? {1'b0, stb.data[STAT_SET_W-1:0]} : '0;
    statClr[ST_RESET] = stb.clrResetBit;
    statSet = {1'b0, statusSet};
    if (stb.setDmaDone) statSet[ST_DMA_DONE] = 1'b1;
    if (stb.txFire)     statSet[ST_TX_DONE]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStat <= STAT_RST;
      intMask <= '0;
      cmdReg  <= CMD_RST;
      txStat  <= '0;
      txReq   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      intStat <= (intStat & ~statClr) | statSet;
      irq     <= |(intStat & intMask & IRQ_FIELD);
      txReq   <= stb.txFire;
      if (stb.txFire) txStat <= TX_STAT_OK;
      if (hit(stb, SEL_INT_MASK)) intMask <= stb.data;
      if (hit(stb, SEL_CMD)) begin
        cmdReg <= stb.data;
        if (stb.txFire) cmdReg[CMD_TX_BIT] <= 1'b0;
      end
    end
  end

  // plain byte registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringFirst <= '0;
      ringLast  <= '0;
      readPtr   <= '0;
      writePg   <= '0;
      rxMode    <= '0;
      txMode    <= '0;
      busCfg    <= '0;
      txPage    <= '0;
      nextRem   <= '0;
      nextLoc   <= '0;
    end else if (stb.wrStb) begin
      case (stb.wrSel)
        SEL_RING_FIRST: ringFirst <= stb.data;
        SEL_RING_LAST:  ringLast  <= stb.data;
        SEL_READ_PTR:   readPtr   <= stb.data;
        SEL_WRITE_PG:   writePg   <= stb.data;
        SEL_RX_MODE:    rxMode    <= stb.data;
        SEL_TX_MODE:    txMode    <= stb.data;
        SEL_BUS_CFG:    busCfg    <= stb.data;
        SEL_TX_PAGE:    txPage    <= stb.data;
        SEL_NEXT_REM:   nextRem   <= stb.data;
        SEL_NEXT_LOC:   nextLoc   <= stb.data;
        default: ;
      endcase
    end
  end

  // 16-bit registers written by byte halves
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCount   <= '0;
      dmaAddr   <= '0;
      dmaLen    <= '0;
      localAddr <= '0;
      addrCnt   <= '0;
    end else if (stb.wrStb) begin
      case (stb.wrSel)
        SEL_TX_LEN_LO:   txCount[7:0]    <= stb.data;
        SEL_TX_LEN_HI:   txCount[15:8]   <= stb.data;
        SEL_DMA_ADDR_LO: dmaAddr[7:0]    <= stb.data;
        SEL_DMA_ADDR_HI: dmaAddr[15:8]   <= stb.data;
        SEL_DMA_LEN_LO:  dmaLen[7:0]     <= stb.data;
        SEL_DMA_LEN_HI:  dmaLen[15:8]    <= stb.data;
        SEL_LOCAL_LO:    localAddr[7:0]  <= stb.data;
        SEL_LOCAL_HI:    localAddr[15:8] <= stb.data;
        SEL_CNT_LO:      addrCnt[7:0]    <= stb.data;
        SEL_CNT_HI:      addrCnt[15:8]   <= stb.data;
        default: ;
      endcase
    end
  end

  // station address and group mask byte arrays
  genvar g;
  generate
    for (g = 0; g < IDX_SLOTS; g++) begin : gSlot
      if (g < STATION_BYTES) begin : gStation
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)
            stationAddr[g*BYTE_W +: BYTE_W] <= STATION_RST[g*BYTE_W +: BYTE_W];
          else if (hit(stb, SEL_STATION) && stb.wrIdx == IDX_W'(g))
            stationAddr[g*BYTE_W +: BYTE_W] <= stb.data;
        end
        assign stationRd[g] = stationAddr[g*BYTE_W +: BYTE_W];
      end else begin : gStationPad
        assign stationRd[g] = '0;
      end
      if (g < GROUP_BYTES) begin : gGroup
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)
            groupMask[g*BYTE_W +: BYTE_W] <= '1;
          else if (hit(stb, SEL_GROUP) && stb.wrIdx == IDX_W'(g))
            groupMask[g*BYTE_W +: BYTE_W] <= stb.data;
        end
        assign groupRd[g] = groupMask[g*BYTE_W +: BYTE_W];
      end else begin : gGroupPad
        assign groupRd[g] = '0;
      end
    end
  endgenerate

  // read mux
  always_comb begin
    rdData = '0;
    if (stb.rdStb) begin
      case (stb.rdSel)
        SEL_CMD:        rdData = cmdReg;
        SEL_LOCAL_LO:   rdData = localAddr[7:0];
        SEL_LOCAL_HI:   rdData = localAddr[15:8];
        SEL_READ_PTR:   rdData = readPtr;
        SEL_TX_STAT:    rdData = txStat;
        SEL_INT_STAT:   rdData = intStat;
        SEL_STATION:    rdData = stationRd[stb.rdIdx];
        SEL_WRITE_PG:   rdData = writePg;
        SEL_GROUP:      rdData = groupRd[stb.rdIdx];
        SEL_RING_FIRST: rdData = ringFirst;
        SEL_RING_LAST:  rdData = ringLast;
        SEL_NEXT_REM:   rdData = nextRem;
        SEL_TX_PAGE:    rdData = txPage;
        SEL_NEXT_LOC:   rdData = nextLoc;
        SEL_CNT_HI:     rdData = addrCnt[15:8];
        SEL_CNT_LO:     rdData = addrCnt[7:0];
        SEL_RX_MODE:    rdData = rxMode;
        SEL_TX_MODE:    rdData = txMode;
        SEL_BUS_CFG:    rdData = busCfg;
        SEL_INT_MASK:   rdData = intMask;
        default:        rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/nic_reg_bank.sv
module nic_reg_bank
  import nic_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [STATION_BYTES*BYTE_W-1:0] STATION_RST = '0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               portAddr,
  input  logic [1:0]                      accSize,
  input  logic                            rdEn,
  input  logic                            wrEn,
  input  logic [BYTE_W-1:0]               wrData,
  output logic [BYTE_W-1:0]               rdData,
  input  logic [STAT_SET_W-1:0]           statusSet,
  output logic                            irq,
  output logic [BYTE_W-1:0]               cmdOut,
  output logic [BYTE_W-1:0]               ringFirst,
  output logic [BYTE_W-1:0]               ringLast,
  output logic [BYTE_W-1:0]               readPtr,
  output logic [BYTE_W-1:0]               writePg,
  output logic [BYTE_W-1:0]               rxMode,
  output logic [BYTE_W-1:0]               txMode,
  output logic [BYTE_W-1:0]               busCfg,
  output logic [WORD_W-1:0]               dmaAddr,
  output logic [WORD_W-1:0]               dmaLen,
  output logic [STATION_BYTES*BYTE_W-1:0] stationAddr,
  output logic [GROUP_BYTES*BYTE_W-1:0]   groupMask,
  output logic                            txReq,
  output logic [BYTE_W-1:0]               txPage,
  output logic [WORD_W-1:0]               txCount
);
  ctrlStb_t          stb;
  logic              dmaLenZero;
  logic [BYTE_W-1:0] intStat;
  logic [BYTE_W-1:0] intMask;

  nic_reg_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .portAddr  (portAddr),
    .accSize   (accSize),
    .rdEn      (rdEn),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .cmdReg    (cmdOut),
    .dmaLenZero(dmaLenZero),
    .stb       (stb)
  );

  nic_reg_dp #(.STATION_RST(STATION_RST)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .statusSet  (statusSet),
    .rdData     (rdData),
    .irq        (irq),
    .cmdReg     (cmdOut),
    .dmaLenZero (dmaLenZero),
    .intStat    (intStat),
    .intMask    (intMask),
    .ringFirst  (ringFirst),
    .ringLast   (ringLast),
    .readPtr    (readPtr),
    .writePg    (writePg),
    .rxMode     (rxMode),
    .txMode     (txMode),
    .busCfg     (busCfg),
    .dmaAddr    (dmaAddr),
    .dmaLen     (dmaLen),
    .stationAddr(stationAddr),
    .groupMask  (groupMask),
    .txReq      (txReq),
    .txPage     (txPage),
    .txCount    (txCount)
  );
endmodule

// File: rtl/nic_reg_bank_chk.sv
module nic_reg_bank_chk (
  input logic       clk,
  input logic       rstN,
  input logic       irq,
  input logic [7:0] intStat,
  input logic [7:0] intMask,
  input logic [6:0] statusSet,
  input logic       txReq,
  input logic [7:0] cmdOut,
  input logic       wrEn,
  input logic [1:0] accSize
);
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    irq == (|($past(intStat) & $past(intMask) & 8'h7F))); // R5

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> !txReq); // R8

  AST_TX_DONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> intStat[1]); // R8

  AST_TX_BIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut[2] |-> cmdOut[0]); // R8

  AST_RESET_BIT_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !intStat[7] |=> !intStat[7]); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|statusSet) |=> ((intStat[6:0] & $past(statusSet)) == $past(statusSet))); // R11

  AST_WIDE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accSize != 2'd0) |=> ($stable(cmdOut) && $stable(intMask))); // R10
endmodule

bind nic_reg_bank nic_reg_bank_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irq      (irq),
  .intStat  (intStat),
  .intMask  (intMask),
  .statusSet(statusSet),
  .txReq    (txReq),
  .cmdOut   (cmdOut),
  .wrEn     (wrEn),
  .accSize  (accSize)
);

// File: tb/test_nic_reg_bank.sv
module test_nic_reg_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  portAddr = '0;
  logic [1:0]  accSize = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [6:0]  statusSet = '0;
  logic        irq;
  logic [7:0]  cmdOut, ringFirst, ringLast, readPtr, writePg, rxMode, txMode, busCfg;
  logic [15:0] dmaAddr, dmaLen;
  logic [47:0] stationAddr;
  logic [63:0] groupMask;
  logic        txReq;
  logic [7:0]  txPage;
  logic [15:0] txCount;

  int runCnt  = 0;
  int failCnt = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_reg_bank i_nic_reg_bank (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .accSize(accSize),
    .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .statusSet(statusSet), .irq(irq), .cmdOut(cmdOut),
    .ringFirst(ringFirst), .ringLast(ringLast), .readPtr(readPtr),
    .writePg(writePg), .rxMode(rxMode), .txMode(txMode), .busCfg(busCfg),
    .dmaAddr(dmaAddr), .dmaLen(dmaLen), .stationAddr(stationAddr),
    .groupMask(groupMask), .txReq(txReq), .txPage(txPage), .txCount(txCount)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    runCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [1:0] sz = 2'd0);
    @(negedge clk);
    portAddr = a; wrData = d; accSize = sz; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; accSize = 2'd0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, input logic [1:0] sz = 2'd0);
    @(negedge clk);
    portAddr = a; accSize = sz; rdEn = 1'b1;
    #1 d = rdData;
    rdEn = 1'b0; accSize = 2'd0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset(); // R1
    rd(8'h00, rv); chk("R1 cmd", rv, 8'h22);
    rd(8'h07, rv); chk("R1 status", rv, 8'h80);
    rd(8'h04, rv); chk("R1 txstat", rv, 8'h00);
    chk("R1 group mask", groupMask, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 irq", irq, 1'b0);
    chk("R1 txReq", txReq, 1'b0);
    wr(8'h00, 8'hA1); // page 2 with stop set, keeps reset bit
    rd(8'h0F, rv); chk("R1 mask", rv, 8'h00);
  endtask

  task automatic testResetBit(); // R6
    wr(8'h00, 8'h21);
    rd(8'h07, rv); chk("R6 stop keeps bit7", rv, 8'h80);
    wr(8'h00, 8'h22);
    rd(8'h07, rv); chk("R6 start clears bit7", rv, 8'h00);
    rd(8'h00, rv); chk("R3 cmd readback", rv, 8'h22);
  endtask

  task automatic testHalves(); // R9, R3, R2
    wr(8'h01, 8'h40); wr(8'h02, 8'h80); wr(8'h04, 8'h47);
    wr(8'h05, 8'h34); wr(8'h06, 8'h12); wr(8'h05, 8'h99);
    chk("R9 tx length halves", txCount, 16'h1299);
    wr(8'h0A, 8'hCD); wr(8'h0B, 8'hAB);
    chk("R9 remote length", dmaLen, 16'hABCD);
    wr(8'h0B, 8'h01);
    chk("R9 keep low half", dmaLen, 16'h01CD);
    wr(8'h08, 8'h10); wr(8'h09, 8'h20);
    chk("R9 remote address", dmaAddr, 16'h2010);
    wr(8'hEF, 8'h42); // low 5 bits select 0x0F: mask
    wr(8'h00, 8'hA2);
    rd(8'h01, rv); chk("R3 page2 ring first", rv, 8'h40);
    rd(8'h02, rv); chk("R3 page2 ring last", rv, 8'h80);
    rd(8'h04, rv); chk("R3 page2 tx page", rv, 8'h47);
    rd(8'h0F, rv); chk("R2 aliased mask write", rv, 8'h42);
    rd(8'h2F, rv); chk("R2 aliased read", rv, 8'h42);
    wr(8'h07, 8'hBE); wr(8'h06, 8'h5A);
    rd(8'h07, rv); chk("R9 counter low", rv, 8'hBE);
    rd(8'h06, rv); chk("R9 counter high", rv, 8'h5A);
    wr(8'h03, 8'h33);
    rd(8'h03, rv); chk("R3 page2 next remote", rv, 8'h33);
    wr(8'h00, 8'h22);
    wr(8'h0F, 8'h00);
  endtask

  task automatic testPage1(); // R3
    wr(8'h00, 8'h62);
    for (int i = 0; i < 6; i++) wr(8'(1 + i), 8'(8'hA0 + i));
    wr(8'h07, 8'h4C);
    wr(8'h08, 8'h00); wr(8'h0F, 8'h3C);
    rd(8'h03, rv); chk("R3 station byte 2", rv, 8'hA2);
    rd(8'h07, rv); chk("R3 write page", rv, 8'h4C);
    rd(8'h0F, rv); chk("R3 group byte 7", rv, 8'h3C);
    chk("R3 station port", stationAddr, 48'hA5A4_A3A2_A1A0);
    chk("R3 group port", groupMask, 64'h3CFF_FFFF_FFFF_FF00);
    rd(8'h00, rv); chk("R3 cmd from page1", rv, 8'h62);
    wr(8'h00, 8'hE2);
    wr(8'h01, 8'h55);
    rd(8'h01, rv); chk("R3 page3 empty", rv, 8'h00);
    wr(8'h00, 8'h62);
    rd(8'h01, rv); chk("R3 page3 write ignored", rv, 8'hA0);
    wr(8'h00, 8'h22);
  endtask

  task automatic testIgnored(); // R10
    rd(8'h0A, rv); chk("R10 unimplemented read", rv, 8'h00);
    rd(8'h1A, rv); chk("R10 upper offsets read", rv, 8'h00);
    wr(8'h00, 8'hE1, 2'd1);
    rd(8'h00, rv); chk("R10 wide write ignored", rv, 8'h22);
    rd(8'h00, rv, 2'd2); chk("R10 wide read zero", rv, 8'h00);
  endtask

  task automatic testStatusIrq(); // R4, R5, R11
    wr(8'h0F, 8'h7F);
    @(negedge clk); statusSet = 7'h05;
    @(negedge clk); statusSet = 7'h00;
    chk("R5 irq lags status", irq, 1'b0);
    @(negedge clk);
    chk("R5 irq raised", irq, 1'b1);
    rd(8'h07, rv); chk("R11 set ORed in", rv, 8'h05);
    wr(8'h07, 8'h01);
    rd(8'h07, rv); chk("R4 clear bit0 only", rv, 8'h04);
    wr(8'h07, 8'hFC);
    chk("R5 irq still old value", irq, 1'b1);
    @(negedge clk);
    chk("R5 irq dropped", irq, 1'b0);
    rd(8'h07, rv); chk("R4 cleared", rv, 8'h00);
    @(negedge clk);
    portAddr = 8'h07; wrData = 8'h02; wrEn = 1'b1; statusSet = 7'h02;
    @(negedge clk);
    wrEn = 1'b0; statusSet = 7'h00;
    rd(8'h07, rv); chk("R11 set beats clear", rv, 8'h02);
    wr(8'h07, 8'h7F);
    wr(8'h0F, 8'h00);
  endtask

  task automatic testDmaDone(); // R7
    wr(8'h0A, 8'h00); wr(8'h0B, 8'h00);
    wr(8'h00, 8'h0A);
    rd(8'h07, rv); chk("R7 zero length read done", rv, 8'h40);
    wr(8'h07, 8'h40);
    wr(8'h00, 8'h12);
    rd(8'h07, rv); chk("R7 zero length write done", rv, 8'h40);
    wr(8'h07, 8'h40);
    wr(8'h0A, 8'h01);
    wr(8'h00, 8'h0A);
    rd(8'h07, rv); chk("R7 nonzero length no flag", rv, 8'h00);
    wr(8'h00, 8'h22);
  endtask

  task automatic testTransmit(); // R8
    @(negedge clk);
    portAddr = 8'h00; wrData = 8'h26; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R8 txReq high", txReq, 1'b1);
    chk("R8 tx page", txPage, 8'h47);
    chk("R8 tx count", txCount, 16'h1299);
    @(negedge clk);
    chk("R8 txReq one cycle", txReq, 1'b0);
    rd(8'h00, rv); chk("R8 transmit bit cleared", rv, 8'h22);
    rd(8'h07, rv); chk("R8 transmit done bit", rv, 8'h02);
    rd(8'h04, rv); chk("R8 transmit status", rv, 8'h01);
    wr(8'h07, 8'h02);
    @(negedge clk);
    portAddr = 8'h00; wrData = 8'h25; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R8 stopped no request", txReq, 1'b0);
    rd(8'h07, rv); chk("R8 stopped no done bit", rv, 8'h00);
    wr(8'h00, 8'h22);
  endtask

  task automatic testResetBitMasked(); // R5
    doReset();
    wr(8'h0F, 8'hFF);
    repeat (2) @(negedge clk);
    chk("R5 bit7 never interrupts", irq, 1'b0);
    rd(8'h07, rv); chk("R1 status after second reset", rv, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testResetBit();
    testHalves();
    testPage1();
    testIgnored();
    testStatusIrq();
    testDmaDone();
    testTransmit();
    testResetBitMasked();
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    runCnt++;
    failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule